// File: doc/BRIEF.md
# ModR/M Instruction Length Calculator

This block works out how many bytes a memory-operand instruction occupies. Its inputs are the number of prefix bytes already seen, a two-bit cycle class, a two-bit immediate class, the ModR/M byte, the byte after it (which may be a SIB byte), and flags for 32-bit operand size and 32-bit address size. From these it returns the total byte count. It also reports whether the encoding carries an address displacement and whether a SIB byte is present.

A pairing or issue stage uses the result to decide whether two instructions fit the window of a parallel decoder. That stage holds the opcode tables and spots the prefixes. This block only counts bytes.

An input strobe is captured on a clock edge and the result appears on the registered outputs on the following cycle. Instructions whose class does not touch memory return the prefix count alone.

Top module: `modrm_len_calc`

## Requirements
- R1: While reset is asserted, and after it until the first strobe, out_valid, out_len, out_has_disp and out_has_sib are all 0.
- R2: out_valid is 1 exactly in the cycle after a cycle with in_valid high. The data outputs then reflect the inputs sampled with that strobe. In a cycle after one without a strobe, out_len, out_has_disp and out_has_sib keep their previous values.
- R3: Cycle class encoding: 0 = register only, 1 = memory read, 2 = memory read-modify-write, 3 = branch. Only classes 1 and 2 add bytes beyond the prefix count. For classes 0 and 3 the length equals in_prefix_cnt and both flags are 0.
- R4: For memory classes, 2 bytes are added for opcode and ModR/M. Immediate class 1 adds 1 byte. Immediate class 2 adds 4 bytes when in_opsize32 is 1 and 2 bytes when it is 0. Immediate classes 0 and 3 add nothing.
- R5: With in_addrsize32 = 1, a memory class, rm = in_modrm[2:0] = 100 and mod = in_modrm[7:6] not equal to 11, a SIB byte is present. It adds 1 byte and sets out_has_sib.
- R6: With 32-bit addressing, mod = 01 adds a 1-byte displacement and mod = 10 adds a 4-byte displacement.
- R7: With 32-bit addressing and mod = 00, a 4-byte displacement is added when a SIB byte is present and its base field in_sib[2:0] is 101, or when no SIB byte is present and rm is 101. Otherwise nothing is added.
- R8: With 16-bit addressing, mod = 01 adds 1 byte, mod = 10 adds 2 bytes, and mod = 00 with rm = 110 adds 2 bytes. No SIB byte is ever counted and out_has_sib stays 0.
- R9: out_has_disp is 1 exactly when R6, R7 or R8 add displacement bytes.
- R10: With mod = 11 under a memory class, no SIB or displacement bytes are added and the length is the prefix count plus 2 plus the immediate bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: sample the inputs this cycle |
| in_prefix_cnt | input | PFX_W | Number of prefix bytes ahead of the opcode |
| in_cycle_class | input | 2 | Cycle class code (R3) |
| in_imm_class | input | 2 | Immediate class code (R4) |
| in_modrm | input | 8 | ModR/M byte |
| in_sib | input | 8 | Byte following ModR/M, used as SIB when present |
| in_opsize32 | input | 1 | 1 when the operand size is 32 bits |
| in_addrsize32 | input | 1 | 1 when the address size is 32 bits |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_len | output | LEN_W | Instruction length in bytes |
| out_has_disp | output | 1 | Encoding carries a displacement |
| out_has_sib | output | 1 | Encoding carries a SIB byte |

## Verification
The bench builds the block with its defaults: a 4-bit prefix count, 4-byte and 2-byte immediates, and a 5-bit length. At this size every ModR/M value can be paired with every SIB value under 32-bit addressing, and every ModR/M value can be swept under 16-bit addressing. The full range of prefix counts is crossed with all cycle and immediate classes and both size flags. That cross reaches the longest encoding, 26 bytes, which uses the top bit of the length output.

// File: rtl/modrm_len_pkg.sv
package modrm_len_pkg;

   // cycle class codes seen at the block edge
   typedef enum logic [1:0] {
      CYC_REG    = 2'd0,
      CYC_MEMRD  = 2'd1,
      CYC_MEMRMW = 2'd2,
      CYC_BRANCH = 2'd3
   } cyc_class_e;

   // immediate class codes
   typedef enum logic [1:0] {
      IMM_NONE = 2'd0,
      IMM_BYTE = 2'd1,
      IMM_WORD = 2'd2,
      IMM_RSVD = 2'd3
   } imm_class_e;

   // ModR/M field values that steer the decode
   localparam logic [1:0] MOD_NODISP = 2'b00;
   localparam logic [1:0] MOD_DISP8  = 2'b01;
   localparam logic [1:0] MOD_DFULL  = 2'b10;
   localparam logic [1:0] MOD_REGOP  = 2'b11;
   localparam logic [2:0] RM_SIB_ESC = 3'b100;
   localparam logic [2:0] RM_ABS32   = 3'b101;
   localparam logic [2:0] RM_ABS16   = 3'b110;
   localparam logic [2:0] BASE_ABS   = 3'b101;

   // fixed byte counts of the encoding
   localparam int OPC_MODRM_BYTES = 2;
   localparam int SIB_BYTES       = 1;
   localparam int DISP8_BYTES     = 1;
   localparam int DISP16_BYTES    = 2;
   localparam int DISP32_BYTES    = 4;

   // width of any single byte-count field
   localparam int BYTE_CNT_W = 3;

   typedef struct packed {
      logic                  has_sib;
      logic                  has_disp;
      logic [BYTE_CNT_W-1:0] disp_bytes;
   } ea_info_t;

   function automatic logic is_mem_class(input logic [1:0] cls);
      return (cls == CYC_MEMRD) || (cls == CYC_MEMRMW);
   endfunction

endpackage

// File: rtl/modrm_ea_decode.sv
module modrm_ea_decode
   import modrm_len_pkg::*;
#(
   parameter bit ADDR32 = 1'b1
) (
   input  logic [1:0] mod_f,
   input  logic [2:0] rm_f,
   input  logic [2:0] sib_base,
   output ea_info_t   info
);

   generate
      if (ADDR32) begin : g_a32
         logic sib_here;
         assign sib_here = (rm_f == RM_SIB_ESC) && (mod_f != MOD_REGOP);

         always_comb begin
            info          = '0;
            info.has_sib  = sib_here;
            unique case (mod_f)
               MOD_DISP8: begin
                  info.disp_bytes = BYTE_CNT_W'(DISP8_BYTES);
                  info.has_disp   = 1'b1;
               end
               MOD_DFULL: begin
                  info.disp_bytes = BYTE_CNT_W'(DISP32_BYTES);
                  info.has_disp   = 1'b1;
               end
               MOD_NODISP: begin
                  if ((sib_here && sib_base == BASE_ABS) ||
                      (!sib_here && rm_f == RM_ABS32)) begin
                     info.disp_bytes = BYTE_CNT_W'(DISP32_BYTES);
                     info.has_disp   = 1'b1;
                  end
               end
               default: begin
               end
            endcase
         end
      end else begin : g_a16
         logic unused_base;
         assign unused_base = ^sib_base;

         always_comb begin
            info = '0;
            unique case (mod_f)
               MOD_DISP8: begin
                  info.disp_bytes = BYTE_CNT_W'(DISP8_BYTES);
                  info.has_disp   = 1'b1;
               end
               MOD_DFULL: begin
                  info.disp_bytes = BYTE_CNT_W'(DISP16_BYTES);
                  info.has_disp   = 1'b1;
               end
               MOD_NODISP: begin
                  if (rm_f == RM_ABS16) begin
                     info.disp_bytes = BYTE_CNT_W'(DISP16_BYTES);
                     info.has_disp   = 1'b1;
                  end
               end
               default: begin
               end
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/modrm_imm_size.sv
module modrm_imm_size
   import modrm_len_pkg::*;
#(
   parameter int LONG_BYTES  = 4,
   parameter int SHORT_BYTES = 2,
   parameter int CNT_W       = BYTE_CNT_W
) (
   input  logic [1:0]       imm_class,
   input  logic             opsize32,
   output logic [CNT_W-1:0] imm_bytes
);

   localparam int CNT_MAX = (1 << CNT_W) - 1;

   generate
      if (LONG_BYTES > CNT_MAX || SHORT_BYTES > CNT_MAX) begin : g_bad_width
         $error("immediate byte count does not fit its field");
      end
      if (SHORT_BYTES < 1 || LONG_BYTES < SHORT_BYTES) begin : g_bad_order
         $error("immediate sizes must satisfy 1 <= short <= long");
      end
   endgenerate

   always_comb begin
      imm_bytes = '0;
      unique case (imm_class)
         IMM_BYTE: imm_bytes = CNT_W'(1);
         IMM_WORD: imm_bytes = opsize32 ? CNT_W'(LONG_BYTES) : CNT_W'(SHORT_BYTES);
         default:  imm_bytes = '0;
      endcase
   end

endmodule

// File: rtl/modrm_len_sum.sv
module modrm_len_sum
   import modrm_len_pkg::*;
#(
   parameter int PFX_W = 4,
   parameter int LEN_W = 5
) (
   input  logic [PFX_W-1:0]      pfx_cnt,
   input  logic                  mem_form,
   input  logic [BYTE_CNT_W-1:0] imm_bytes,
   input  ea_info_t              info,
   output logic [LEN_W-1:0]      len,
   output logic                  has_disp,
   output logic                  has_sib
);

   generate
      if (LEN_W < PFX_W) begin : g_bad_len
         $error("length field narrower than prefix count");
      end
   endgenerate

   logic [LEN_W-1:0] body;

   always_comb begin
      body = '0;
      if (mem_form) begin
         body = LEN_W'(OPC_MODRM_BYTES) + LEN_W'(imm_bytes) +
                LEN_W'(info.disp_bytes);
         if (info.has_sib) body = body + LEN_W'(SIB_BYTES);
      end
      len = LEN_W'(pfx_cnt) + body;
   end

   assign has_disp = mem_form & info.has_disp;
   assign has_sib  = mem_form & info.has_sib;

   always_comb begin
      // R9
      disp_flag_chk: assert (info.has_disp == (info.disp_bytes != '0));
   end

endmodule

// File: rtl/modrm_len_calc.sv
module modrm_len_calc
   import modrm_len_pkg::*;
#(
   parameter int PFX_W            = 4,
   parameter int OPND_LONG_BYTES  = 4,
   parameter int OPND_SHORT_BYTES = 2,
   localparam int MAX_LEN = (1 << PFX_W) - 1 + OPC_MODRM_BYTES + OPND_LONG_BYTES +
                            SIB_BYTES + DISP32_BYTES,
   localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [PFX_W-1:0] in_prefix_cnt,
   input  logic [1:0]       in_cycle_class,
   input  logic [1:0]       in_imm_class,
   input  logic [7:0]       in_modrm,
   input  logic [7:0]       in_sib,
   input  logic             in_opsize32,
   input  logic             in_addrsize32,
   output logic             out_valid,
   output logic [LEN_W-1:0] out_len,
   output logic             out_has_disp,
   output logic             out_has_sib
);

   generate
      if (PFX_W < 1) begin : g_bad_pfx
         $error("prefix count needs at least one bit");
      end
   endgenerate

   logic [1:0] mod_f;
   logic [2:0] rm_f;
   logic       unused_fields;

   assign mod_f         = in_modrm[7:6];
   assign rm_f          = in_modrm[2:0];
   assign unused_fields = ^{in_modrm[5:3], in_sib[7:3]};

   ea_info_t ea16, ea32, ea_sel;

   modrm_ea_decode #(.ADDR32(1'b0)) u_ea16 (
      .mod_f    (mod_f),
      .rm_f     (rm_f),
      .sib_base (in_sib[2:0]),
      .info     (ea16)
   );

   modrm_ea_decode #(.ADDR32(1'b1)) u_ea32 (
      .mod_f    (mod_f),
      .rm_f     (rm_f),
      .sib_base (in_sib[2:0]),
      .info     (ea32)
   );

   assign ea_sel = in_addrsize32 ? ea32 : ea16;

   logic [BYTE_CNT_W-1:0] imm_bytes;

   modrm_imm_size #(
      .LONG_BYTES  (OPND_LONG_BYTES),
      .SHORT_BYTES (OPND_SHORT_BYTES),
      .CNT_W       (BYTE_CNT_W)
   ) u_imm (
      .imm_class (in_imm_class),
      .opsize32  (in_opsize32),
      .imm_bytes (imm_bytes)
   );

   logic             mem_form;
   logic [LEN_W-1:0] len_c;
   logic             disp_c, sib_c;

   assign mem_form = is_mem_class(in_cycle_class);

   modrm_len_sum #(.PFX_W(PFX_W), .LEN_W(LEN_W)) u_sum (
      .pfx_cnt   (in_prefix_cnt),
      .mem_form  (mem_form),
      .imm_bytes (imm_bytes),
      .info      (ea_sel),
      .len       (len_c),
      .has_disp  (disp_c),
      .has_sib   (sib_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_len      <= '0;
         out_has_disp <= 1'b0;
         out_has_sib  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_len      <= len_c;
            out_has_disp <= disp_c;
            out_has_sib  <= sib_c;
         end
      end
   end

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

   // R2
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> ($stable(out_len) && $stable(out_has_disp) && $stable(out_has_sib)));

   // R3
   regform_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !is_mem_class($past(in_cycle_class))) |->
      (out_len == LEN_W'($past(in_prefix_cnt)) && !out_has_disp && !out_has_sib));

   // R5
   sib_addr32_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_has_sib) |->
      ($past(in_addrsize32) && $past(in_modrm[2:0]) == RM_SIB_ESC));

   // R8
   no_sib16_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !$past(in_addrsize32)) |-> !out_has_sib);

   // R10
   regmod_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(in_modrm[7:6]) == MOD_REGOP) |-> (!out_has_disp && !out_has_sib));

endmodule

// File: tb/modrm_len_calc_bench.sv
`timescale 1ns/1ps
module modrm_len_calc_bench;

   localparam int PFX_W = 4;
   localparam int LEN_W = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [PFX_W-1:0] in_prefix_cnt = '0;
   logic [1:0]       in_cycle_class = '0;
   logic [1:0]       in_imm_class = '0;
   logic [7:0]       in_modrm = '0;
   logic [7:0]       in_sib = '0;
   logic             in_opsize32 = 1'b0;
   logic             in_addrsize32 = 1'b0;
   logic             out_valid;
   logic [LEN_W-1:0] out_len;
   logic             out_has_disp;
   logic             out_has_sib;

   modrm_len_calc #(.PFX_W(PFX_W)) u_modrm_len_calc (
      .clk            (clk),
      .rst_n          (rst_n),
      .in_valid       (in_valid),
      .in_prefix_cnt  (in_prefix_cnt),
      .in_cycle_class (in_cycle_class),
      .in_imm_class   (in_imm_class),
      .in_modrm       (in_modrm),
      .in_sib         (in_sib),
      .in_opsize32    (in_opsize32),
      .in_addrsize32  (in_addrsize32),
      .out_valid      (out_valid),
      .out_len        (out_len),
      .out_has_disp   (out_has_disp),
      .out_has_sib    (out_has_sib)
   );

   always #10 clk = ~clk;

   int    checks = 0;
   int    failures = 0;
   bit    done = 1'b0;
   bit    pend = 1'b0;
   int    exp_len = 0;
   bit    exp_disp = 1'b0;
   bit    exp_sib = 1'b0;
   string pend_tag = "";

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // behavioural length model built from the requirement text
   task automatic model(input int pfx, input int cls, input int imm, input int m, input int s,
                        input bit op32, input bit a32,
                        output int len, output bit disp, output bit sib);
      int mo, rm, d, ib;
      bit sp;
      len = pfx; disp = 0; sib = 0;
      if (cls == 1 || cls == 2) begin
         mo = (m >> 6) & 3;
         rm = m & 7;
         sp = a32 && rm == 4 && mo != 3;
         d  = 0;
         if (a32) begin
            if (mo == 1) d = 1;
            else if (mo == 2) d = 4;
            else if (mo == 0 && (sp ? ((s & 7) == 5) : (rm == 5))) d = 4;
         end else begin
            if (mo == 1) d = 1;
            else if (mo == 2) d = 2;
            else if (mo == 0 && rm == 6) d = 2;
         end
         ib = (imm == 1) ? 1 : (imm == 2) ? (op32 ? 4 : 2) : 0;
         len  = pfx + 2 + ib + (sp ? 1 : 0) + d;
         disp = d != 0;
         sib  = sp;
      end
   endtask

   task automatic check_pending();
      if (pend) begin
         chk(out_valid == 1'b1, {"R2 valid ", pend_tag}, int'(out_valid), 1);
         chk(int'(out_len) == exp_len, {"len ", pend_tag}, int'(out_len), exp_len);
         chk(out_has_disp == exp_disp, {"R9 disp ", pend_tag}, int'(out_has_disp), int'(exp_disp));
         chk(out_has_sib == exp_sib, {"sib ", pend_tag}, int'(out_has_sib), int'(exp_sib));
      end
   endtask

   task automatic issue(input int pfx, input int cls, input int imm, input int m, input int s,
                        input bit op32, input bit a32, input string tag);
      @(negedge clk);
      check_pending();
      in_valid       = 1'b1;
      in_prefix_cnt  = PFX_W'(pfx);
      in_cycle_class = 2'(cls);
      in_imm_class   = 2'(imm);
      in_modrm       = 8'(m);
      in_sib         = 8'(s);
      in_opsize32    = op32;
      in_addrsize32  = a32;
      model(pfx, cls, imm, m, s, op32, a32, exp_len, exp_disp, exp_sib);
      pend     = 1'b1;
      pend_tag = tag;
   endtask

   task automatic drain();
      @(negedge clk);
      check_pending();
      in_valid = 1'b0;
      pend     = 1'b0;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired before the sweep ended");
         summary();
         $finish;
      end
   end

   initial begin
      int hold_len;
      bit hold_disp, hold_sib;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
      chk(out_len == '0, "R1 len in reset", int'(out_len), 0);
      chk(out_has_disp == 1'b0, "R1 disp in reset", int'(out_has_disp), 0);
      chk(out_has_sib == 1'b0, "R1 sib in reset", int'(out_has_sib), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
      chk(out_len == '0, "R1 len after reset", int'(out_len), 0);

      // R5 R6 R7 R10: every ModR/M with every SIB, 32-bit addressing
      for (int m = 0; m < 256; m++)
         for (int s = 0; s < 256; s++)
            issue(0, 1, 0, m, s, 1'b0, 1'b1, $sformatf("R5 R6 R7 R10 a32 modrm=%0h sib=%0h", m, s));
      drain();

      // R8 R10: every ModR/M, 16-bit addressing, SIB-like bytes ignored
      for (int m = 0; m < 256; m++) begin
         issue(1, 2, 0, m, 8'h24, 1'b1, 1'b0, $sformatf("R8 R10 a16 modrm=%0h", m));
         issue(2, 1, 0, m, 8'hFD, 1'b0, 1'b0, $sformatf("R8 R10 a16 modrm=%0h", m));
      end
      drain();

      // R3 R4: all prefix counts, classes, immediates and size flags
      for (int p = 0; p < 16; p++)
         for (int c = 0; c < 4; c++)
            for (int i = 0; i < 4; i++)
               for (int o = 0; o < 2; o++)
                  for (int a = 0; a < 2; a++)
                     for (int k = 0; k < 7; k++) begin
                        int mm;
                        case (k)
                           0: mm = 8'h04;
                           1: mm = 8'h45;
                           2: mm = 8'h84;
                           3: mm = 8'hC4;
                           4: mm = 8'h05;
                           5: mm = 8'h06;
                           default: mm = 8'h86;
                        endcase
                        issue(p, c, i, mm, 8'h25, o[0], a[0],
                              $sformatf("R3 R4 pfx=%0d cls=%0d imm=%0d op32=%0d a32=%0d modrm=%0h",
                                        p, c, i, o, a, mm));
                     end
      drain();

      // R4: longest encoding fills the length field (15+2+4+1+4 = 26)
      issue(15, 2, 2, 8'h84, 8'h00, 1'b1, 1'b1, "R4 R5 R6 maximum length");
      @(negedge clk);
      check_pending();
      pend = 1'b0;
      hold_len  = exp_len;
      hold_disp = exp_disp;
      hold_sib  = exp_sib;
      chk(int'(out_len) == 26, "R4 maximum length", int'(out_len), 26);
      // R2: inputs change without a strobe; outputs must hold
      in_valid       = 1'b0;
      in_prefix_cnt  = '0;
      in_cycle_class = 2'd0;
      in_modrm       = 8'hC0;
      in_addrsize32  = 1'b0;
      @(negedge clk);
      chk(out_valid == 1'b0, "R2 no strobe valid", int'(out_valid), 0);
      chk(int'(out_len) == hold_len, "R2 hold len", int'(out_len), hold_len);
      chk(out_has_disp == hold_disp, "R2 hold disp", int'(out_has_disp), int'(hold_disp));
      chk(out_has_sib == hold_sib, "R2 hold sib", int'(out_has_sib), int'(hold_sib));
      @(negedge clk);
      chk(int'(out_len) == hold_len, "R2 hold len second cycle", int'(out_len), hold_len);

      // R7: mod=00 SIB base corner cases
      issue(0, 1, 0, 8'h04, 8'h05, 1'b0, 1'b1, "R7 sib base 101");
      issue(0, 1, 0, 8'h04, 8'h04, 1'b0, 1'b1, "R7 sib base 100");
      issue(0, 1, 0, 8'h05, 8'h05, 1'b0, 1'b1, "R7 rm 101 no sib");
      issue(0, 1, 0, 8'h44, 8'h05, 1'b0, 1'b1, "R7 R6 mod01 sib base 101");
      drain();
      @(negedge clk);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule